// File: doc/BRIEF.md
# Keyed Watchdog Timer with Posted Writes

The block is a watchdog peripheral on a small synchronous register bus. A free-running up-counter advances on a slow-domain tick (nominally 32 kHz), optionally slowed by a power-of-two prescaler. Software keeps the system alive by writing a refresh register, which reloads the counter from a programmable reload value. If the counter wraps past all-ones while the watchdog is armed, the block pulses a reset request and reloads itself.

Arming and disarming are each guarded by a two-word key sequence written to a key register. Writes aimed at the slow domain are posted. Each target register has its own pending flag, which software can poll. The flag stays up until the write has landed, and further writes to that register are dropped while it is up.

The slow domain is modelled as a one-cycle enable strobe `slow_tick` in the bus clock domain. Every slow-domain action happens on a cycle where that strobe is high.

Top module: `wdt_keyed`

## Requirements
- R1: After reset the watchdog is armed, the counter reads 0, the reload value reads 0, the control register reads 0 and the pending register reads 0.
- R2: A read at byte offset 0x00 returns the revision code parameter (default 0x31) in bits 7:0 and zero above. Control is at 0x04, reload at 0x08, refresh at 0x0C, key at 0x10, pending at 0x14 and counter at 0x18.
- R3: A write to control, reload, refresh or key sets its pending bit (bit 0, 2, 3 or 4 of the pending register) in the next cycle. The write takes effect on the LAT-th slow tick after it (default LAT = 3), and the bit clears on that same tick.
- R4: A write to a register whose pending bit is set is ignored.
- R5: While armed with the prescaler off (control bit 5 = 0), the counter rises by one on every slow tick.
- R6: With control bit 5 = 1 and ratio r in control bits 4:2, the counter rises once every 2^r slow ticks. The prescaler phase restarts when a refresh takes effect.
- R7: A refresh write of any data value loads the counter with the reload value when it takes effect.
- R8: When the armed counter advances from all-ones, `rst_req` is high for exactly one cycle and the counter reloads from the reload value.
- R9: Writing 0x0000BBBB and then 0x00004444 to the key register arms the watchdog.
- R10: Writing 0x0000AAAA and then 0x00005555 to the key register disarms the watchdog. While disarmed, the counter holds and no reset request is raised.
- R11: A second key word that does not match the pending first word, or a second word that arrives with no first word, cancels the sequence and leaves the armed state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle strobe marking each slow-domain tick |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write when high during bus_sel |
| bus_addr | input | AW (8) | Byte address of the register |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, combinational from bus_addr |
| rst_req | output | 1 | One-cycle reset request on overflow |

## Verification
The bench goes after the window in which a posted write is still in flight. If pending bits clear one tick early, the old control value reads back at the wrong tick. If writes made during the window are not blocked, a second reload value overwrites the first. It sweeps the prescaler ratio and tick counts against a reference formula. A prescaler whose phase is not restarted by refresh, or that is off by one, misses that formula. It drives the counter across its wrap and checks for a single-cycle request followed by a reload. It also tries broken, reversed and lone key words, under which a weak sequencer would flip the armed state.

// File: rtl/wdt_keyed.sv
module wdt_keyed #(
  parameter int DW = 32,
  parameter int AW = 8,
  parameter int LAT = 3,
  parameter logic [7:0] REV = 8'h31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slow_tick,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          rst_req
);
  localparam int LW = $clog2(LAT + 1);
  localparam int PW = 7;
  localparam logic [AW-1:0] A_REV  = AW'(8'h00);
  localparam logic [AW-1:0] A_PEND = AW'(8'h14);
  localparam logic [AW-1:0] A_CNT  = AW'(8'h18);

  typedef enum logic [1:0] {SQ_IDLE, SQ_ARM1, SQ_DIS1} seq_t;

  logic [3:0]    hit, pend, apply;
  logic [5:0]    ctrl_q, ctrl_stg;
  logic [DW-1:0] load_q, load_stg, key_stg, cnt_q;
  logic [PW-1:0] pre_q, pre_top;
  logic          armed_q, req_q, pre_last, step, ovf;
  seq_t          seq_q;

  for (genvar i = 0; i < 4; i++) begin : g_slot
    logic          p_q;
    logic [LW-1:0] lat_q;
    assign hit[i]   = bus_sel && bus_wr && bus_addr == AW'(4 + 4 * i);
    assign pend[i]  = p_q;
    assign apply[i] = p_q && slow_tick && lat_q == LW'(1);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        p_q   <= 1'b0;
        lat_q <= '0;
      end else if (hit[i] && !p_q) begin
        p_q   <= 1'b1;
        lat_q <= LW'(LAT);
      end else if (p_q && slow_tick) begin
        lat_q <= lat_q - LW'(1);
        if (lat_q == LW'(1)) p_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_stg <= '0;
      load_stg <= '0;
      key_stg  <= '0;
    end else begin
      if (hit[0] && !pend[0]) ctrl_stg <= bus_wdata[5:0];
      if (hit[1] && !pend[1]) load_stg <= bus_wdata;
      if (hit[3] && !pend[3]) key_stg  <= bus_wdata;
    end
  end

  assign pre_top  = (PW'(1) << ctrl_q[4:2]) - PW'(1);
  assign pre_last = !ctrl_q[5] || pre_q == pre_top;
  assign step     = slow_tick && armed_q && pre_last;
  assign ovf      = step && (&cnt_q) && !apply[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      load_q  <= '0;
      cnt_q   <= '0;
      pre_q   <= '0;
      armed_q <= 1'b1;
      seq_q   <= SQ_IDLE;
      req_q   <= 1'b0;
    end else begin
      req_q <= ovf;
      if (apply[0]) ctrl_q <= ctrl_stg;
      if (apply[1]) load_q <= load_stg;
      if (apply[2]) begin
        cnt_q <= load_q;
        pre_q <= '0;
      end else if (slow_tick && armed_q) begin
        pre_q <= pre_last ? '0 : pre_q + PW'(1);
        if (pre_last) cnt_q <= (&cnt_q) ? load_q : cnt_q + DW'(1);
      end
      if (apply[3]) begin
        if (key_stg == DW'(16'hBBBB)) seq_q <= SQ_ARM1;
        else if (key_stg == DW'(16'hAAAA)) seq_q <= SQ_DIS1;
        else begin
          seq_q <= SQ_IDLE;
          if (key_stg == DW'(16'h4444) && seq_q == SQ_ARM1) armed_q <= 1'b1;
          if (key_stg == DW'(16'h5555) && seq_q == SQ_DIS1) armed_q <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_REV:      bus_rdata = DW'(REV);
      AW'(8'h04): bus_rdata = DW'(ctrl_q);
      AW'(8'h08): bus_rdata = load_q;
      A_PEND:     bus_rdata = DW'({pend[3], pend[2], pend[1], 1'b0, pend[0]});
      A_CNT:      bus_rdata = cnt_q;
      default:    bus_rdata = '0;
    endcase
  end

  assign rst_req = req_q;
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk #(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          slow_tick,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic          rst_req,
  input logic          armed,
  input logic [3:0]    pend,
  input logic [DW-1:0] cnt,
  input logic [DW-1:0] load
);
  a_r8_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  a_r10_req_needs_armed: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(armed));
  a_r10_frozen_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !pend[2]) |=> $stable(cnt));
  a_r4_load_only_on_apply: assert property (@(posedge clk) disable iff (!rst_n)
    !pend[1] |=> $stable(load));
  a_r3_pend_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend[0]) |-> $past(bus_sel && bus_wr && bus_addr == AW'(8'h04)));
  a_r3_load_pend_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[1] && !slow_tick) |=> pend[1]);
  a_r3_key_pend_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[3] && !slow_tick) |=> pend[3]);
endmodule

bind wdt_keyed wdt_keyed_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_sel(bus_sel),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .rst_req(rst_req), .armed(armed_q),
  .pend(pend), .cnt(cnt_q), .load(load_q)
);

// File: tb/wdt_keyed_test.sv
module wdt_keyed_test;
  localparam int LAT = 3;
  localparam logic [7:0] A_REV = 8'h00, A_CTRL = 8'h04, A_LOAD = 8'h08,
                         A_TRIG = 8'h0C, A_KEY = 8'h10, A_PEND = 8'h14, A_CNT = 8'h18;

  logic clk = 0, rst_n = 0, slow_tick = 0, bus_sel = 0, bus_wr = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic rst_req;
  int n_chk = 0, n_bad = 0, n_req = 0;

  wdt_keyed #(.LAT(LAT)) uut (.clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rst_req(rst_req));

  always #5 clk = ~clk;
  always @(posedge clk) if (rst_n && rst_req) n_req++;

  function automatic logic [31:0] exp_count(logic [31:0] base, int ticks, int r, bit en);
    return base + 32'(en ? (ticks >> r) : ticks);
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic tick(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); slow_tick = 1;
      @(negedge clk); slow_tick = 0;
    end
  endtask

  task automatic post(logic [7:0] a, logic [31:0] d);
    wr(a, d);
    tick(LAT);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired (R1..) got=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v, c, lv, patt;
    int r, t, n0;
    bit en;
    void'($urandom(7));
    repeat (3) @(negedge clk);
    rst_n = 1;

    rd(A_CNT, v);  chk("R1 count", v, 0);
    rd(A_LOAD, v); chk("R1 load", v, 0);
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_PEND, v); chk("R1 pend", v, 0);
    rd(A_REV, v);  chk("R2 rev", v, 32'h31);
    tick(3);
    rd(A_CNT, v);  chk("R1 armed at reset", v, 3);

    wr(A_CTRL, 32'h2C);
    rd(A_PEND, v); chk("R3 ctrl pend set", v, 32'h1);
    tick(LAT - 1);
    rd(A_PEND, v); chk("R3 ctrl pend held", v, 32'h1);
    rd(A_CTRL, v); chk("R3 ctrl not yet", v, 0);
    tick(1);
    rd(A_PEND, v); chk("R3 ctrl pend clear", v, 0);
    rd(A_CTRL, v); chk("R3 ctrl applied", v, 32'h2C);
    post(A_CTRL, 0);

    wr(A_LOAD, 100);
    wr(A_LOAD, 200);
    rd(A_PEND, v); chk("R3 load pend bit2", v, 32'h4);
    tick(LAT);
    rd(A_LOAD, v); chk("R4 second write ignored", v, 100);

    wr(A_TRIG, 32'h1234);
    rd(A_PEND, v); chk("R3 trig pend bit3", v, 32'h8);
    tick(LAT);
    rd(A_CNT, v);  chk("R7 refresh reload", v, 100);
    post(A_TRIG, ~32'h1234);
    rd(A_CNT, v);  chk("R7 refresh inverse", v, 100);
    tick(7);
    rd(A_CNT, v);  chk("R5 count up", v, 107);

    wr(A_KEY, 32'hBBBB);
    rd(A_PEND, v); chk("R3 key pend bit4", v, 32'h10);
    tick(LAT);

    patt = 32'h1234;
    for (int it = 0; it < 12; it++) begin
      r = $urandom % 5;
      en = it[0];
      lv = $urandom & 32'h0FFF_FFFF;
      t = $urandom % 40;
      post(A_CTRL, en ? (32'h20 | 32'(r << 2)) : 32'h0);
      post(A_LOAD, lv);
      patt = ~patt;
      post(A_TRIG, patt);
      rd(A_CNT, v); chk("R7 random reload", v, lv);
      tick(t);
      rd(A_CNT, v);
      chk(en ? "R6 prescaled count" : "R5 plain count", v, exp_count(lv, t, r, en));
    end

    post(A_CTRL, 0);
    post(A_LOAD, 32'hFFFF_FFFE);
    post(A_TRIG, 1);
    n0 = n_req;
    tick(1);
    rd(A_CNT, v); chk("R8 at all-ones", v, 32'hFFFF_FFFF);
    chk("R8 no early req", 32'(n_req), 32'(n0));
    tick(1);
    @(negedge clk);
    chk("R8 single pulse", 32'(n_req), 32'(n0 + 1));
    rd(A_CNT, v); chk("R8 reload after wrap", v, 32'hFFFF_FFFE);

    post(A_LOAD, 0);
    post(A_TRIG, 2);
    post(A_KEY, 32'hAAAA);
    post(A_KEY, 32'h5555);
    n0 = n_req;
    rd(A_CNT, c); tick(20);
    rd(A_CNT, v); chk("R10 disarmed holds", v, c);
    chk("R10 no req disarmed", 32'(n_req), 32'(n0));

    post(A_KEY, 32'h4444);
    rd(A_CNT, c); tick(5);
    rd(A_CNT, v); chk("R11 lone second word", v, c);
    post(A_KEY, 32'hBBBB);
    post(A_KEY, 32'h1234);
    post(A_KEY, 32'h4444);
    rd(A_CNT, c); tick(5);
    rd(A_CNT, v); chk("R11 broken arm seq", v, c);

    post(A_KEY, 32'hBBBB);
    post(A_KEY, 32'h4444);
    rd(A_CNT, c); tick(5);
    rd(A_CNT, v); chk("R9 armed counts", v, c + 5);

    post(A_KEY, 32'hAAAA);
    post(A_KEY, 32'h4444);
    rd(A_CNT, c); tick(4);
    rd(A_CNT, v); chk("R11 mismatched pair stays armed", v, c + 4);
    post(A_KEY, 32'h5555);
    rd(A_CNT, c); tick(4);
    rd(A_CNT, v); chk("R11 cancelled seq stays armed", v, c + 4);

    finish_run();
  end
endmodule